// File: doc/BRIEF.md
# Video DAC Digital Front End

This block is the clocked digital side of a three-channel video digital-to-analog converter. On each rising clock edge it captures one byte per colour channel and three line controls: a sync flag, a blanking flag (active low) and a force-white flag. It decides which of them wins, and for every channel it registers the code the converter should turn into current. It also registers three enables for that channel: the current sources, the black-level pedestal and the separate sync current.

Each channel also reports the level it should produce, in millivolts, worked out with integer arithmetic. A bench or a system model can compare that figure against the expected analog picture. One channel, chosen by a parameter and green by default, carries the sync current. A sleep input that acts without the clock turns every current enable off at once and freezes the captured state until it is released.

Top module: `vdac_front`

## Requirements
- R1: Pixel bytes and the three controls are captured together on a rising clock edge, and every output reflects the values captured at the most recent edge on which sleep was low and reset was not applied.
- R2: When the captured blanking flag is 0, every channel outputs code 0 with its pedestal and current enables at 0, whatever the white flag and pixel bytes were. A channel without sync reports 0 mV.
- R3: When blanking is 1 and white is 1, all channels output code 255 with pedestal and current enables at 1, ignoring the pixel bytes.
- R4: When blanking is 1 and white is 0, channel k outputs its own byte, taken from `pix_in[8k+7:8k]` (k=0 red, 1 green, 2 blue), with pedestal and current enables at 1.
- R5: Bit `SYNC_CH` (default 1, green) of `sync_en` equals the captured sync flag, independent of blanking and white. Every other bit of `sync_en` is always 0.
- R6: With blanking at 1, a channel reports 54 + round(code*660/255) mV, plus 286 mV if it is the sync channel and sync is 1.
- R7: With blanking at 0, the sync channel reports 286 mV if sync is 1 and 0 mV (sync tip) if sync is 0.
- R8: While `sleep` is 1, `ped_en`, `cur_en` and `sync_en` are all 0 straight away, with no clock edge needed.
- R9: While `sleep` is 1, clock edges do not update any register, so `code_out` and `level_mv` hold. The first edge after `sleep` returns to 0 captures new inputs. Once `sleep` is 0 the enables show the held state again.
- R10: A synchronous active-high reset, which takes priority over sleep, clears every output to 0. This is the blanked sync-tip state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Power-down, gates enables asynchronously and freezes registers |
| pix_in | input | 24 | Three pixel bytes, red in the low byte |
| sync_in | input | 1 | Sync flag, 1 = sync current on |
| blank_in | input | 1 | Blanking flag, 0 = blanked |
| white_in | input | 1 | Force full-scale flag |
| code_out | output | 24 | Codes to convert, same byte order as `pix_in` |
| ped_en | output | 3 | Pedestal enable per channel |
| cur_en | output | 3 | Conversion current enable per channel |
| sync_en | output | 3 | Sync current enable per channel |
| level_mv | output | 33 | Nominal level per channel, 11 bits each, red lowest |

## Verification
The bench uses the default build: three 8-bit channels, green as the sync channel and 11-bit levels. With only 256 codes per channel, it sweeps every code through all three channels, checks the rounded millivolt figure at each code against the formula, and alternates sync so that the sync offset is seen landing on green only. All eight combinations of sync, blanking and white are then applied to a fixed pixel pattern. Sleep is asserted and released between clock edges, so the immediate gating of the enables and the freezing of the codes can both be seen apart from any edge.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
  // Rounded data part of the level: code * span / full_code, to nearest.
  function automatic int unsigned data_mv(input int unsigned code,
                                          input int unsigned span,
                                          input int unsigned full_code);
    return (code * span + full_code / 2) / full_code;
  endfunction
endpackage

// File: rtl/vdac_resolve.sv
module vdac_resolve #(
  parameter int CODE_W   = 8,
  parameter int LVL_W    = 11,
  parameter bit HAS_SYNC = 1'b0,
  parameter int PED_MV   = 54,
  parameter int SPAN_MV  = 660,
  parameter int SYNC_MV  = 286
) (
  input  logic [CODE_W-1:0] pix,
  input  logic              blank_n,
  input  logic              white,
  input  logic              sync,
  output logic [CODE_W-1:0] code,
  output logic              ped,
  output logic              cur,
  output logic              snc,
  output logic [LVL_W-1:0]  lvl
);
  import vdac_pkg::*;
  localparam int unsigned FULL = (1 << CODE_W) - 1;

  int unsigned sum;

  always_comb begin
    // blanking beats white, white beats pixel data
    if (!blank_n)   code = '0;
    else if (white) code = '1;
    else            code = pix;
    ped = blank_n;
    cur = blank_n;
    snc = HAS_SYNC && sync;
    sum = 0;
    if (blank_n) sum = PED_MV + data_mv(int'(code), SPAN_MV, FULL);
    if (snc)     sum = sum + SYNC_MV;
    lvl = LVL_W'(sum);
  end
endmodule

// File: rtl/vdac_chan_reg.sv
module vdac_chan_reg #(
  parameter int CODE_W = 8,
  parameter int LVL_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [CODE_W-1:0] code_d,
  input  logic              ped_d,
  input  logic              cur_d,
  input  logic              snc_d,
  input  logic [LVL_W-1:0]  lvl_d,
  output logic [CODE_W-1:0] code_q,
  output logic              ped_q,
  output logic              cur_q,
  output logic              snc_q,
  output logic [LVL_W-1:0]  lvl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ped_q  <= 1'b0;
      cur_q  <= 1'b0;
      snc_q  <= 1'b0;
      lvl_q  <= '0;
    end else if (!hold) begin
      code_q <= code_d;
      ped_q  <= ped_d;
      cur_q  <= cur_d;
      snc_q  <= snc_d;
      lvl_q  <= lvl_d;
    end
  end
endmodule

// File: rtl/vdac_front.sv
module vdac_front #(
  parameter int CODE_W  = 8,
  parameter int NUM_CH  = 3,
  parameter int SYNC_CH = 1,
  parameter int LVL_W   = 11,
  parameter int PED_MV  = 54,
  parameter int SPAN_MV = 660,
  parameter int SYNC_MV = 286
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sleep,
  input  logic [NUM_CH*CODE_W-1:0] pix_in,
  input  logic                     sync_in,
  input  logic                     blank_in,
  input  logic                     white_in,
  output logic [NUM_CH*CODE_W-1:0] code_out,
  output logic [NUM_CH-1:0]        ped_en,
  output logic [NUM_CH-1:0]        cur_en,
  output logic [NUM_CH-1:0]        sync_en,
  output logic [NUM_CH*LVL_W-1:0]  level_mv
);
  logic [NUM_CH-1:0] ped_q, cur_q, snc_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [CODE_W-1:0] code_d;
    logic              ped_d, cur_d, snc_d;
    logic [LVL_W-1:0]  lvl_d;

    vdac_resolve #(
      .CODE_W(CODE_W), .LVL_W(LVL_W), .HAS_SYNC(k == SYNC_CH),
      .PED_MV(PED_MV), .SPAN_MV(SPAN_MV), .SYNC_MV(SYNC_MV)
    ) u_res (
      .pix(pix_in[k*CODE_W +: CODE_W]), .blank_n(blank_in),
      .white(white_in), .sync(sync_in),
      .code(code_d), .ped(ped_d), .cur(cur_d), .snc(snc_d), .lvl(lvl_d)
    );

    vdac_chan_reg #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_reg (
      .clk(clk), .rst(rst), .hold(sleep),
      .code_d(code_d), .ped_d(ped_d), .cur_d(cur_d), .snc_d(snc_d), .lvl_d(lvl_d),
      .code_q(code_out[k*CODE_W +: CODE_W]), .ped_q(ped_q[k]), .cur_q(cur_q[k]),
      .snc_q(snc_q[k]), .lvl_q(level_mv[k*LVL_W +: LVL_W])
    );
  end

  // sleep gates every current enable without waiting for the clock
  assign ped_en  = sleep ? '0 : ped_q;
  assign cur_en  = sleep ? '0 : cur_q;
  assign sync_en = sleep ? '0 : snc_q;
endmodule

// File: rtl/vdac_front_chk.sv
module vdac_front_chk #(
  parameter int CODE_W  = 8,
  parameter int NUM_CH  = 3,
  parameter int SYNC_CH = 1,
  parameter int LVL_W   = 11
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sleep,
  input logic [NUM_CH*CODE_W-1:0] pix_in,
  input logic                     sync_in,
  input logic                     blank_in,
  input logic                     white_in,
  input logic [NUM_CH*CODE_W-1:0] code_out,
  input logic [NUM_CH-1:0]        ped_en,
  input logic [NUM_CH-1:0]        cur_en,
  input logic [NUM_CH-1:0]        sync_en,
  input logic [NUM_CH*LVL_W-1:0]  level_mv
);
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !blank_in) |=> (code_out == '0 && cur_en == '0)); // R2
  AST_WHITE_FULL: assert property (@(posedge clk) disable iff (rst)
    (!sleep && blank_in && white_in) |=> (code_out == '1)); // R3
  AST_PIX_PASS: assert property (@(posedge clk) disable iff (rst)
    (!sleep && blank_in && !white_in) |=> (code_out == $past(pix_in))); // R4
  AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!sleep) |=> (sleep || sync_en[SYNC_CH] == $past(sync_in))); // R5
  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (ped_en == '0 && cur_en == '0 && sync_en == '0)); // R8
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sleep)) |-> ($stable(code_out) && $stable(level_mv))); // R9
endmodule

bind vdac_front vdac_front_chk #(
  .CODE_W(CODE_W), .NUM_CH(NUM_CH), .SYNC_CH(SYNC_CH), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rst(rst), .sleep(sleep), .pix_in(pix_in), .sync_in(sync_in),
  .blank_in(blank_in), .white_in(white_in), .code_out(code_out),
  .ped_en(ped_en), .cur_en(cur_en), .sync_en(sync_en), .level_mv(level_mv)
);

// File: tb/vdac_front_tb_top.sv
module vdac_front_tb_top;
  localparam int PERIOD = 10;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 1'b0;
  logic [23:0] pix_in = '0;
  logic sync_in = 1'b0, blank_in = 1'b0, white_in = 1'b0;
  logic [23:0] code_out;
  logic [2:0]  ped_en, cur_en, sync_en;
  logic [32:0] level_mv;

  int checks = 0;
  int failures = 0;

  always #(PERIOD/2) clk = ~clk;

  vdac_front dut_i (
    .clk(clk), .rst(rst), .sleep(sleep), .pix_in(pix_in), .sync_in(sync_in),
    .blank_in(blank_in), .white_in(white_in), .code_out(code_out),
    .ped_en(ped_en), .cur_en(cur_en), .sync_en(sync_en), .level_mv(level_mv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lvl(int ch, int code, bit s, bit b);
    int v = 0;
    if (b) v = 54 + (code * 1320 + 255) / 510;
    if (ch == 1 && s) v += 286;
    return v;
  endfunction

  // inputs change at the falling edge, results sampled 1 time unit after rising edge
  task automatic drive_step(input logic [23:0] p, input bit s, input bit b, input bit w);
    @(negedge clk);
    pix_in = p; sync_in = s; blank_in = b; white_in = w;
    @(posedge clk); #1;
  endtask

  task automatic check_all(input logic [23:0] p, input bit s, input bit b, input bit w);
    for (int k = 0; k < NCH; k++) begin
      int ec = !b ? 0 : (w ? 255 : int'(p[k*8 +: 8]));
      string rq = !b ? "R2" : (w ? "R3" : "R4");
      chk(code_out[k*8 +: 8] == 8'(ec), rq, int'(code_out[k*8 +: 8]), ec);
      chk(ped_en[k] == b && cur_en[k] == b, rq, int'({ped_en[k], cur_en[k]}), int'({b, b}));
      chk(sync_en[k] == (k == 1 && s), "R5", int'(sync_en[k]), int'(k == 1 && s));
      chk(int'(level_mv[k*11 +: 11]) == exp_lvl(k, ec, s, b),
          (k == 1 && !b) ? "R7" : "R6", int'(level_mv[k*11 +: 11]), exp_lvl(k, ec, s, b));
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] held_code;
    logic [32:0] held_lvl;
    // R10: reset state, with sleep also requested during reset
    pix_in = 24'hffffff; blank_in = 1'b1; white_in = 1'b1; sync_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(code_out == '0 && level_mv == '0, "R10", int'(code_out), 0);
    chk(ped_en == '0 && cur_en == '0 && sync_en == '0, "R10",
        int'({ped_en, cur_en, sync_en}), 0);
    @(negedge clk); sleep = 1'b1;
    @(posedge clk); #1;
    chk(code_out == '0, "R10", int'(code_out), 0);
    @(negedge clk); rst = 1'b0; sleep = 1'b0;

    // R1 R4 R6 R5: every code on every channel, sync alternating
    for (int c = 0; c < 256; c++) begin
      logic [23:0] p = {8'(c) ^ 8'h5a, 8'(255 - c), 8'(c)};
      drive_step(p, c[0], 1'b1, 1'b0);
      check_all(p, c[0], 1'b1, 1'b0);
    end

    // R2 R3 R7: all control combinations on a fixed pattern
    for (int m = 0; m < 8; m++) begin
      drive_step(24'h80_3c_c3, m[0], m[1], m[2]);
      check_all(24'h80_3c_c3, m[0], m[1], m[2]);
    end

    // R1: single-edge latency, one step after another with no gap
    drive_step(24'h01_02_03, 1'b1, 1'b1, 1'b0);
    drive_step(24'h0a_0b_0c, 1'b0, 1'b1, 1'b0);
    chk(code_out == 24'h0a_0b_0c && sync_en == 3'b000, "R1", int'(code_out), 24'h0a0b0c);

    // R8 R9: sleep between edges
    drive_step(24'h11_22_33, 1'b1, 1'b1, 1'b0);
    held_code = code_out; held_lvl = level_mv;
    #2 sleep = 1'b1;
    #1;
    chk(ped_en == '0 && cur_en == '0 && sync_en == '0, "R8",
        int'({ped_en, cur_en, sync_en}), 0);
    for (int i = 0; i < 4; i++) begin
      drive_step(24'hee_dd_cc, 1'b0, 1'b0, 1'b1);
      chk(code_out == held_code && level_mv == held_lvl, "R9",
          int'(code_out), int'(held_code));
      chk(cur_en == '0 && sync_en == '0, "R8", int'({cur_en, sync_en}), 0);
    end
    @(negedge clk); sleep = 1'b0;
    #1;
    chk(code_out == held_code && cur_en == 3'b111 && sync_en == 3'b010, "R9",
        int'({cur_en, sync_en}), int'({3'b111, 3'b010}));
    @(posedge clk); #1;
    check_all(24'hee_dd_cc, 1'b0, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule